// File: doc/BRIEF.md
# Synchronous Fault Status Capture

This block sits next to a translation and bus unit. It records the memory-access faults that the unit reports, so that a fault handler can later find out what went wrong. Each fault arrives as a one-cycle strobe. The strobe carries a fault code, an access classification, the page-table depth at which the fault was found, four error flags, and a virtual address with its own valid bit.

Software sees two registers through a plain read port: a status word and a fault-address register. Error flags and the address-valid bit are sticky. They pile up across faults until software reads the status word, and that read empties the status. The descriptive fields (fault code, access class, level) always show the most recent fault. An overwrite bit tells the handler that a second fault arrived before the first one had been read. Reading the address register has no side effect.

Top module: `fault_status_capture`

## Requirements
- R1: An active-low reset clears the status word and the address register to zero, and it does so asynchronously.
- R2: A fault strobe writes its 3-bit fault code into status bits 4:2, replacing the previous code. The codes are 0 none, 1 invalid address, 2 protection, 3 privilege, 4 translation, 5 bus error on access, 6 internal, 7 reserved.
- R3: A fault strobe writes its 3-bit access class into status bits 7:5, replacing the previous class. Bit 5 set means supervisor, bit 6 set means instruction fetch, and bit 7 set means store.
- R4: A fault strobe writes its 2-bit table level into status bits 9:8. The levels are 0 context, 1 region, 2 segment, 3 page.
- R5: The error flags map to status bits as follows: bus error is bit 10, timeout is bit 11, uncorrectable is bit 12, and control-space error is bit 16. Each flag, once set, stays set across later faults until a status read.
- R6: Status bit 1 is set by any fault whose address is valid, and it stays set until a status read.
- R7: Status bit 0 is set when a fault arrives while an earlier fault has not yet been read through the status word.
- R8: A read with `rd_sel_i`=0 returns the status word in the same cycle and clears all status bits at the next clock edge.
- R9: A read with `rd_sel_i`=1 returns the fault-address register. That register loads only on a fault with a valid address, and a fault without one leaves it unchanged.
- R10: Reading the address register leaves the status word unchanged.
- R11: When a fault and a status read fall in the same cycle, the status afterwards holds only that fault's bits, with bit 0 clear.
- R12: `rd_data_o` is zero whenever `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flt_valid_i | input | 1 | Fault event strobe, one cycle per fault |
| flt_type_i | input | 3 | Fault code |
| flt_acc_i | input | 3 | Access class: bit0 supervisor, bit1 instruction, bit2 store |
| flt_lvl_i | input | 2 | Table level at which the fault was detected |
| flt_bus_err_i | input | 1 | Bus error flag |
| flt_timeout_i | input | 1 | Bus timeout flag |
| flt_uncorr_i | input | 1 | Uncorrectable data error flag |
| flt_ctrl_sp_i | input | 1 | Control-space error flag |
| flt_addr_vld_i | input | 1 | Fault address is meaningful |
| flt_addr_i | input | ADDR_W | Faulting virtual address |
| rd_en_i | input | 1 | Register read enable |
| rd_sel_i | input | 1 | 0 selects status (clears it), 1 selects address |
| rd_data_o | output | DATA_W | Read data |

## Verification
The properties assume that every input is free of X and held steady across each clock edge. They also assume that a strobe stands for exactly one fault, so a strobe held high for two cycles counts as two faults and sets the overwrite bit. Field and flag inputs are treated as don't-care while `flt_valid_i` is low. The bench drives every input at the falling edge and keeps each strobe to one cycle. It zeroes all field and flag inputs between events, so no property sees a half-formed fault.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int unsigned OW_BIT  = 0;
  localparam int unsigned FAV_BIT = 1;
  localparam int unsigned FT_LSB  = 2;
  localparam int unsigned AT_LSB  = 5;
  localparam int unsigned LVL_LSB = 8;
  localparam int unsigned BE_BIT  = 10;
  localparam int unsigned TO_BIT  = 11;
  localparam int unsigned UC_BIT  = 12;
  localparam int unsigned CS_BIT  = 16;
  localparam int unsigned ERR_N   = 4;
  localparam int unsigned STAT_W  = 17;

  // error flag index -> status bit position
  localparam int unsigned ERR_POS [ERR_N] = '{BE_BIT, TO_BIT, UC_BIT, CS_BIT};

  typedef struct packed {
    logic [2:0]       ftype;
    logic [2:0]       acc;
    logic [1:0]       lvl;
    logic [ERR_N-1:0] err;   // {cs, uc, to, be}
  } fault_t;

  typedef struct packed {
    logic [ERR_N-1:0] err;
    logic [1:0]       lvl;
    logic [2:0]       acc;
    logic [2:0]       ftype;
    logic             fav;
    logic             ow;
  } stat_t;
endpackage

// File: rtl/fsc_status_reg.sv
module fsc_status_reg
  import fsc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   evt_valid_i,
  input  fault_t evt_i,
  input  logic   evt_addr_vld_i,
  input  logic   clr_i,
  output stat_t  stat_o,
  output logic   pending_o
);
  stat_t stat_q, stat_d, base;
  logic  pend_q, pend_d, pend_base;

  always_comb begin
    base      = clr_i ? '0 : stat_q;
    pend_base = clr_i ? 1'b0 : pend_q;
    stat_d    = base;
    pend_d    = pend_base;
    if (evt_valid_i) begin
      stat_d.ftype = evt_i.ftype;
      stat_d.acc   = evt_i.acc;
      stat_d.lvl   = evt_i.lvl;
      stat_d.err   = base.err | evt_i.err;
      stat_d.fav   = base.fav | evt_addr_vld_i;
      stat_d.ow    = base.ow | pend_base;
      pend_d       = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      pend_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
      pend_q <= pend_d;
    end
  end

  assign stat_o    = stat_q;
  assign pending_o = pend_q;
endmodule

// File: rtl/fsc_addr_reg.sv
module fsc_addr_reg #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= addr_i;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/fsc_read_mux.sv
module fsc_read_mux
  import fsc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              rd_en_i,
  input  logic              rd_sel_i,
  input  stat_t             stat_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned ADDR_PAD = DATA_W - ADDR_W;

  logic [DATA_W-1:0] stat_word;

  always_comb begin
    stat_word                   = '0;
    stat_word[OW_BIT]           = stat_i.ow;
    stat_word[FAV_BIT]          = stat_i.fav;
    stat_word[FT_LSB  +: 3]     = stat_i.ftype;
    stat_word[AT_LSB  +: 3]     = stat_i.acc;
    stat_word[LVL_LSB +: 2]     = stat_i.lvl;
    for (int i = 0; i < int'(ERR_N); i++) stat_word[ERR_POS[i]] = stat_i.err[i];
  end

  logic [DATA_W-1:0] addr_word;
  generate
    if (ADDR_PAD > 0) begin : g_pad
      assign addr_word = {{ADDR_PAD{1'b0}}, addr_i};
    end else begin : g_nopad
      assign addr_word = addr_i[DATA_W-1:0];
    end
  endgenerate

  assign data_o = !rd_en_i ? '0 : (rd_sel_i ? addr_word : stat_word);
endmodule

// File: rtl/fault_status_capture.sv
module fault_status_capture
  import fsc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flt_valid_i,
  input  logic [2:0]        flt_type_i,
  input  logic [2:0]        flt_acc_i,
  input  logic [1:0]        flt_lvl_i,
  input  logic              flt_bus_err_i,
  input  logic              flt_timeout_i,
  input  logic              flt_uncorr_i,
  input  logic              flt_ctrl_sp_i,
  input  logic              flt_addr_vld_i,
  input  logic [ADDR_W-1:0] flt_addr_i,
  input  logic              rd_en_i,
  input  logic              rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o
);
  fault_t            evt;
  stat_t             stat;
  logic              pending;
  logic              stat_clr;
  logic [ADDR_W-1:0] addr_q;

  assign evt.ftype = flt_type_i;
  assign evt.acc   = flt_acc_i;
  assign evt.lvl   = flt_lvl_i;
  assign evt.err   = {flt_ctrl_sp_i, flt_uncorr_i, flt_timeout_i, flt_bus_err_i};
  assign stat_clr  = rd_en_i && !rd_sel_i;

  fsc_status_reg u_status (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .evt_valid_i    (flt_valid_i),
    .evt_i          (evt),
    .evt_addr_vld_i (flt_addr_vld_i),
    .clr_i          (stat_clr),
    .stat_o         (stat),
    .pending_o      (pending)
  );

  fsc_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (flt_valid_i && flt_addr_vld_i),
    .addr_i (flt_addr_i),
    .addr_o (addr_q)
  );

  fsc_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .rd_en_i  (rd_en_i),
    .rd_sel_i (rd_sel_i),
    .stat_i   (stat),
    .addr_i   (addr_q),
    .data_o   (rd_data_o)
  );
endmodule

// File: rtl/fault_status_capture_chk.sv
module fault_status_capture_chk
  import fsc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flt_valid_i,
  input logic [2:0]        flt_type_i,
  input logic              flt_addr_vld_i,
  input logic [ADDR_W-1:0] flt_addr_i,
  input logic              rd_en_i,
  input logic              rd_sel_i,
  input stat_t             stat,
  input logic              pending,
  input logic [ADDR_W-1:0] addr_q,
  input logic [DATA_W-1:0] rd_data_o
);
  logic st_rd;
  assign st_rd = rd_en_i && !rd_sel_i;

  assert_fault_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_valid_i |=> stat.ftype == $past(flt_type_i));

  assert_err_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat.err[0] && !st_rd) |=> stat.err[0]);

  assert_fav_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat.fav && !st_rd) |=> stat.fav);

  assert_overwrite_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_valid_i && pending && !st_rd) |=> stat.ow);

  assert_read_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_rd && !flt_valid_i) |=> (stat == '0 && !pending));

  assert_addr_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_valid_i && flt_addr_vld_i) |=> addr_q == $past(flt_addr_i));

  assert_addr_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flt_valid_i && flt_addr_vld_i) |=> $stable(addr_q));

  assert_addr_read_keeps_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_sel_i && !flt_valid_i) |=> $stable(stat));

  assert_same_cycle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_valid_i && st_rd) |=> !stat.ow);

  assert_idle_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> rd_data_o == '0);
endmodule

bind fault_status_capture fault_status_capture_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .flt_valid_i    (flt_valid_i),
  .flt_type_i     (flt_type_i),
  .flt_addr_vld_i (flt_addr_vld_i),
  .flt_addr_i     (flt_addr_i),
  .rd_en_i        (rd_en_i),
  .rd_sel_i       (rd_sel_i),
  .stat           (stat),
  .pending        (pending),
  .addr_q         (addr_q),
  .rd_data_o      (rd_data_o)
);

// File: tb/fault_status_capture_bench.sv
`timescale 1ns/1ps
module fault_status_capture_bench;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          flt_valid = 1'b0;
  logic [2:0]    flt_type = '0, flt_acc = '0;
  logic [1:0]    flt_lvl = '0;
  logic          be = 1'b0, to = 1'b0, uc = 1'b0, cs = 1'b0, av = 1'b0;
  logic [AW-1:0] flt_addr = '0;
  logic          rd_en = 1'b0, rd_sel = 1'b0;
  logic [DW-1:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  fault_status_capture #(.ADDR_W(AW), .DATA_W(DW)) u_fault_status_capture (
    .clk_i(clk), .rst_ni(rst_ni), .flt_valid_i(flt_valid), .flt_type_i(flt_type),
    .flt_acc_i(flt_acc), .flt_lvl_i(flt_lvl), .flt_bus_err_i(be), .flt_timeout_i(to),
    .flt_uncorr_i(uc), .flt_ctrl_sp_i(cs), .flt_addr_vld_i(av), .flt_addr_i(flt_addr),
    .rd_en_i(rd_en), .rd_sel_i(rd_sel), .rd_data_o(rd_data)
  );

  typedef struct packed {
    logic [2:0]  ty;
    logic [2:0]  acc;
    logic [1:0]  lvl;
    logic        be, to, uc, cs, av;
    logic [31:0] addr;
    logic [31:0] exp_st;
    logic [31:0] exp_addr;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 3'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h1000_0040, 32'h0000_0306, 32'h1000_0040},
    '{3'd2, 3'd5, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'hDEAD_BEE0, 32'h0000_02AA, 32'hDEAD_BEE0},
    '{3'd5, 3'd2, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h5555_5555, 32'h0000_0454, 32'hDEAD_BEE0},
    '{3'd4, 3'd7, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_0FFC, 32'h0000_19F2, 32'h0000_0FFC},
    '{3'd6, 3'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'hAAAA_AAAA, 32'h0001_0338, 32'h0000_0FFC},
    '{3'd7, 3'd6, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFFC, 32'h0001_1EDE, 32'hFFFF_FFFC}
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_fault(input logic [2:0] t, input logic [2:0] a, input logic [1:0] l,
                           input logic b, input logic o, input logic u, input logic c,
                           input logic v, input logic [AW-1:0] ad);
    flt_valid = 1'b1; flt_type = t; flt_acc = a; flt_lvl = l;
    be = b; to = o; uc = u; cs = c; av = v; flt_addr = ad;
  endtask

  task automatic clr_fault();
    flt_valid = 1'b0; flt_type = '0; flt_acc = '0; flt_lvl = '0;
    be = 0; to = 0; uc = 0; cs = 0; av = 0; flt_addr = '0;
  endtask

  task automatic fault(input logic [2:0] t, input logic [2:0] a, input logic [1:0] l,
                       input logic b, input logic o, input logic u, input logic c,
                       input logic v, input logic [AW-1:0] ad);
    set_fault(t, a, l, b, o, u, c, v, ad);
    @(negedge clk);
    clr_fault();
  endtask

  task automatic rd(input logic sel, output logic [DW-1:0] d);
    rd_en = 1'b1; rd_sel = sel;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0; rd_sel = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rd(1'b0, d); check("R1 status after reset", d, '0);
    rd(1'b1, d); check("R1 address after reset", d, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    rd(1'b0, d); check("R1 status zero out of reset", d, '0);
    #1 check("R12 idle read data", rd_data, '0);

    // table walk: one fault, address read, status read, confirm cleared
    for (int i = 0; i < NV; i++) begin
      fault(VECS[i].ty, VECS[i].acc, VECS[i].lvl, VECS[i].be, VECS[i].to,
            VECS[i].uc, VECS[i].cs, VECS[i].av, VECS[i].addr);
      rd(1'b1, d); check("R9 address register", d, VECS[i].exp_addr);
      rd(1'b0, d); check("R2 R3 R4 R5 R6 status fields", d, VECS[i].exp_st);
      rd(1'b0, d); check("R8 status cleared by read", d, '0);
    end

    // accumulation and overwrite
    fault(3'd1, 3'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0040);
    fault(3'd3, 3'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
    rd(1'b1, d); check("R9 address held without valid", d, 32'h0000_0040);
    #1 check("R12 idle after read", rd_data, '0);
    rd(1'b0, d); check("R5 R6 R7 accumulate and overwrite (R10 no clear on address read)", d, 32'h0000_0C0F);
    rd(1'b0, d); check("R8 cleared", d, '0);

    // same-cycle fault and status read
    fault(3'd5, 3'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    set_fault(3'd2, 3'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
    rd(1'b0, d);
    clr_fault();
    check("R11 read returns prior status", d, 32'h0000_0414);
    rd(1'b1, d);
    rd(1'b0, d); check("R11 only new fault kept", d, 32'h0000_0808);

    // pending state after the combined cycle sets overwrite
    fault(3'd2, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    fault(3'd1, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    rd(1'b0, d); check("R7 overwrite flagged", d, 32'h0000_0005);

    // mid-run reset
    fault(3'd4, 3'd7, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 32'h1234_5678);
    rst_ni = 1'b0;
    rd(1'b0, d); check("R1 status cleared by reset", d, '0);
    rd(1'b1, d); check("R1 address cleared by reset", d, '0);
    rst_ni = 1'b1;
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule